// File: doc/BRIEF.md
# Scratchpad write-and-copy controller

This block stages writes into non-volatile storage through an 8-byte scratchpad. A host streams one write transaction as bytes: a command byte, the low and high halves of a 16-bit target address, then up to eight data bytes. The block forces the target onto an 8-byte boundary. It keeps a status byte whose top bit flags an incomplete load. Once the eighth data byte has arrived, it presents the inverted CRC-16 of everything received, so the host can confirm the transfer.

A separate copy request commits the scratchpad. Two destinations exist: a data store of four 32-byte pages, and an 8-byte secret area at target address 0x0080. The copy is refused, leaving storage untouched, when the load was incomplete, when the target page is write protected, when a data-page copy lacks the authorization input, or when the target lies outside both areas. One page can be set so that a commit stores the AND of old and new contents, so bits only move from 1 to 0. Both areas sit in one synchronous single-port RAM. A plain host read port exposes the data pages only.

Top module: `scp_top`

## Requirements
- R1: After reset the status byte reads 0xD8, the target address reads 0x0000, and crc_valid, busy, copy_done and copy_err are all low.
- R2: The target address output carries the high byte exactly as sent and the low byte with bits [2:0] forced to zero.
- R3: When the eighth data byte is accepted, status bit 7 (partial flag) clears, and status bits [2:0] become 7 (index of the last data byte written). The status then reads 0x5F.
- R4: A transaction that ends (in_end) after fewer than eight data bytes leaves bit 7 set. Bits [2:0] hold the index of the last data byte received, or 0 if none was received.
- R5: Status bits 6, 4 and 3 always read 1 and bit 5 always reads 0.
- R6: In the cycle after the eighth data byte is clocked in, crc_valid is high for exactly one cycle. crc_out then holds the bitwise inverse of a CRC-16 over the command byte, the low address byte as sent, the high address byte and the eight data bytes. The CRC uses the reflected polynomial 0xA001, is seeded with 0 and takes each byte LSB first.
- R7: A copy requested while the partial flag is set raises copy_err for one cycle and changes no stored byte.
- R8: A copy to a data page whose wp_pages bit is set raises copy_err and changes no stored byte.
- R9: A copy to a data page with auth_ok low raises copy_err. A copy to the secret area at 0x0080 succeeds with auth_ok low.
- R10: An accepted copy to a normal page writes the eight scratchpad bytes to the aligned target, byte 0 at the lowest address. copy_done pulses in the eighth cycle after the request edge, and never together with copy_err.
- R11: With eprom_en set, a copy into page eprom_page stores old AND new for each byte, and copy_done pulses in the 17th cycle after the request edge. Other pages are written normally.
- R12: A copy targeting any address that is neither below 0x0080 nor exactly 0x0080 raises copy_err.
- R13: Bytes beyond the eighth data byte of a transaction are ignored: no new CRC pulse, no status change and no scratchpad change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is present on in_byte |
| in_first | input | 1 | With in_valid: this byte is the command byte opening a transaction |
| in_byte | input | 8 | Received byte |
| in_end | input | 1 | Transaction ended by the host |
| crc_valid | output | 1 | One-cycle pulse: crc_out is valid |
| crc_out | output | 16 | Inverted CRC-16 of the transaction |
| ta_out | output | 16 | Aligned target address |
| status_out | output | 8 | Status byte (bit 7 partial flag, bits [2:0] last index) |
| copy_req | input | 1 | Request a commit of the scratchpad |
| auth_ok | input | 1 | Authorization for data-page commits |
| wp_pages | input | NUM_PAGES | Per-page write protection |
| eprom_en | input | 1 | Enable the 1-to-0-only mode on one page |
| eprom_page | input | PW | Page using the 1-to-0-only mode |
| busy | output | 1 | Commit in progress |
| copy_done | output | 1 | One-cycle pulse: commit finished |
| copy_err | output | 1 | One-cycle pulse: commit refused |
| rd_req | input | 1 | Host read of a data byte (ignored while busy) |
| rd_addr | input | DAW | Data byte address |
| rd_valid | output | 1 | rd_data holds the requested byte |
| rd_data | output | 8 | Read data |

## Verification
The hardest state to reach is a commit into the 1-to-0-only page, because its effect shows only when the page already holds known contents. The stimulus first commits a pattern there with the mode disabled, then enables the mode and commits a second pattern. It reads back each byte and expects the AND, and it counts the cycles to completion. The refusal cases are set up the same way: a known pattern is committed first, so a refused copy can be shown to leave every byte intact.

// File: rtl/scp_pkg.sv
package scp_pkg;

  typedef enum logic [1:0] {
    CP_IDLE  = 2'd0,
    CP_READ  = 2'd1,
    CP_WRITE = 2'd2
  } cp_state_t;

  localparam logic [15:0] CRC_POLY_REFL = 16'hA001;

  // Advance a reflected CRC-16 over one byte, LSB first.
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/scp_ram.sv
module scp_ram #(
  parameter int DEPTH = 136,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [7:0]    wdata,
  output logic [7:0]    q
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/scp_rx.sv
module scp_rx
  import scp_pkg::*;
#(
  parameter int SPAD_BYTES = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        busy,
  input  logic                        in_valid,
  input  logic                        in_first,
  input  logic [7:0]                  in_byte,
  input  logic                        in_end,
  output logic                        pf,
  output logic [15:0]                 ta,
  output logic [7:0]                  status,
  output logic                        crc_valid,
  output logic [15:0]                 crc_out,
  output logic [SPAD_BYTES-1:0][7:0]  spad
);
  localparam int LAST = SPAD_BYTES + 2;
  localparam int IW   = $clog2(SPAD_BYTES + 4);
  localparam int SW   = $clog2(SPAD_BYTES);
  localparam logic [7:0] ALIGN_KEEP = ~8'(SPAD_BYTES - 1);

  logic [IW-1:0] idx;
  logic [SW-1:0] slot;
  logic [2:0]    e_q;
  logic [7:0]    ta_lo, ta_hi;
  logic [15:0]   crc_q;

  always_comb slot = SW'(idx - IW'(3));

  always_ff @(posedge clk) begin
    crc_valid <= 1'b0;
    if (rst) begin
      idx     <= '0;
      pf      <= 1'b1;
      e_q     <= '0;
      ta_lo   <= '0;
      ta_hi   <= '0;
      crc_q   <= '0;
      crc_out <= '0;
      spad    <= '0;
    end else if (in_end) begin
      idx <= '0;
    end else if (in_valid && !busy) begin
      if (in_first) begin
        idx   <= IW'(1);
        pf    <= 1'b1;
        e_q   <= '0;
        crc_q <= crc16_byte(16'h0000, in_byte);
      end else if (idx != '0 && idx <= IW'(LAST)) begin
        crc_q <= crc16_byte(crc_q, in_byte);
        idx   <= idx + IW'(1);
        if (idx == IW'(1)) begin
          ta_lo <= in_byte & ALIGN_KEEP;
        end else if (idx == IW'(2)) begin
          ta_hi <= in_byte;
        end else begin
          spad[slot] <= in_byte;
          e_q        <= 3'(slot);
          if (idx == IW'(LAST)) begin
            pf        <= 1'b0;
            crc_valid <= 1'b1;
            crc_out   <= ~crc16_byte(crc_q, in_byte);
          end
        end
      end
    end
  end

  assign ta     = {ta_hi, ta_lo};
  assign status = {pf, 1'b1, 1'b0, 1'b1, 1'b1, e_q};

  assert_crc_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    crc_valid |=> !crc_valid);
  assert_pf_clear_R3: assert property (@(posedge clk) disable iff (rst)
    crc_valid |-> !pf);
  assert_idx_range_R13: assert property (@(posedge clk) disable iff (rst)
    idx <= IW'(LAST + 1));
endmodule

// File: rtl/scp_commit.sv
module scp_commit
  import scp_pkg::*;
#(
  parameter int NUM_PAGES  = 4,
  parameter int PAGE_BYTES = 32,
  parameter int SPAD_BYTES = 8,
  parameter int AW         = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          copy_req,
  input  logic                          pf,
  input  logic [15:0]                   ta,
  input  logic [SPAD_BYTES-1:0][7:0]    spad,
  input  logic                          auth_ok,
  input  logic [NUM_PAGES-1:0]          wp_pages,
  input  logic                          eprom_en,
  input  logic [$clog2(NUM_PAGES)-1:0]  eprom_page,
  input  logic [7:0]                    ram_q,
  output logic                          busy,
  output logic [AW-1:0]                 ram_addr,
  output logic                          ram_we,
  output logic [7:0]                    ram_wdata,
  output logic                          done,
  output logic                          err
);
  localparam int DATA_BYTES = NUM_PAGES * PAGE_BYTES;
  localparam int DAW = $clog2(DATA_BYTES);
  localparam int PBW = $clog2(PAGE_BYTES);
  localparam int PW  = $clog2(NUM_PAGES);
  localparam int SW  = $clog2(SPAD_BYTES);
  localparam int CW  = $clog2(SPAD_BYTES + 1);

  cp_state_t     state;
  logic [CW-1:0] cnt;
  logic [AW-1:0] base_q;
  logic          eprom_act;
  logic [7:0]    old [SPAD_BYTES];

  logic [PW-1:0] page;
  logic          is_data, is_secret, refuse, use_eprom;
  logic [SW-1:0] wr_slot, rd_slot;

  always_comb begin
    page      = ta[DAW-1:PBW];
    is_data   = ta < 16'(DATA_BYTES);
    is_secret = ta == 16'(DATA_BYTES);
    refuse    = pf || !(is_data || is_secret) ||
                (is_data && (wp_pages[page] || !auth_ok));
    use_eprom = is_data && eprom_en && (page == eprom_page);
    wr_slot   = cnt[SW-1:0];
    rd_slot   = SW'(cnt - CW'(1));
  end

  always_ff @(posedge clk) begin
    done <= 1'b0;
    err  <= 1'b0;
    if (rst) begin
      state     <= CP_IDLE;
      cnt       <= '0;
      base_q    <= '0;
      eprom_act <= 1'b0;
    end else begin
      case (state)
        CP_IDLE: begin
          if (copy_req) begin
            if (refuse) begin
              err <= 1'b1;
            end else begin
              base_q    <= is_secret ? AW'(DATA_BYTES) : AW'(ta[DAW-1:0]);
              eprom_act <= use_eprom;
              cnt       <= '0;
              state     <= use_eprom ? CP_READ : CP_WRITE;
            end
          end
        end
        CP_READ: begin
          if (cnt != '0) old[rd_slot] <= ram_q;
          if (cnt == CW'(SPAD_BYTES)) begin
            cnt   <= '0;
            state <= CP_WRITE;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        CP_WRITE: begin
          if (cnt == CW'(SPAD_BYTES - 1)) begin
            cnt   <= '0;
            state <= CP_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: state <= CP_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = state != CP_IDLE;
    ram_addr  = base_q + AW'(cnt);
    ram_we    = state == CP_WRITE;
    ram_wdata = eprom_act ? (spad[wr_slot] & old[wr_slot]) : spad[wr_slot];
  end

  assert_done_after_write_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(state) == CP_WRITE);
  assert_err_from_idle_R7: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(state) == CP_IDLE);
endmodule

// File: rtl/scp_top.sv
module scp_top
  import scp_pkg::*;
#(
  parameter int NUM_PAGES  = 4,
  parameter int PAGE_BYTES = 32,
  parameter int SPAD_BYTES = 8,
  localparam int DATA_BYTES = NUM_PAGES * PAGE_BYTES,
  localparam int PW  = $clog2(NUM_PAGES),
  localparam int DAW = $clog2(DATA_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_first,
  input  logic [7:0]           in_byte,
  input  logic                 in_end,
  output logic                 crc_valid,
  output logic [15:0]          crc_out,
  output logic [15:0]          ta_out,
  output logic [7:0]           status_out,
  input  logic                 copy_req,
  input  logic                 auth_ok,
  input  logic [NUM_PAGES-1:0] wp_pages,
  input  logic                 eprom_en,
  input  logic [PW-1:0]        eprom_page,
  output logic                 busy,
  output logic                 copy_done,
  output logic                 copy_err,
  input  logic                 rd_req,
  input  logic [DAW-1:0]       rd_addr,
  output logic                 rd_valid,
  output logic [7:0]           rd_data
);
  localparam int MEM_DEPTH = DATA_BYTES + SPAD_BYTES;
  localparam int AW  = $clog2(MEM_DEPTH);
  localparam int PBW = $clog2(PAGE_BYTES);

  logic                       pf;
  logic [SPAD_BYTES-1:0][7:0] spad;
  logic [AW-1:0]              c_addr, ram_addr;
  logic                       ram_we;
  logic [7:0]                 ram_wdata, ram_q;

  scp_rx #(.SPAD_BYTES(SPAD_BYTES)) u_rx (
    .clk(clk), .rst(rst), .busy(busy),
    .in_valid(in_valid), .in_first(in_first), .in_byte(in_byte), .in_end(in_end),
    .pf(pf), .ta(ta_out), .status(status_out),
    .crc_valid(crc_valid), .crc_out(crc_out), .spad(spad)
  );

  scp_commit #(
    .NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES),
    .SPAD_BYTES(SPAD_BYTES), .AW(AW)
  ) u_commit (
    .clk(clk), .rst(rst), .copy_req(copy_req), .pf(pf), .ta(ta_out), .spad(spad),
    .auth_ok(auth_ok), .wp_pages(wp_pages), .eprom_en(eprom_en), .eprom_page(eprom_page),
    .ram_q(ram_q), .busy(busy), .ram_addr(c_addr), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .done(copy_done), .err(copy_err)
  );

  assign ram_addr = busy ? c_addr : AW'(rd_addr);

  scp_ram #(.DEPTH(MEM_DEPTH), .AW(AW)) u_ram (
    .clk(clk), .addr(ram_addr), .we(ram_we), .wdata(ram_wdata), .q(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_req && !busy;
  end

  assign rd_data = ram_q;

  assert_full_before_copy_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(!pf));
  assert_wp_respected_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && ($past(ta_out) < 16'(DATA_BYTES))) |-> $past(!wp_pages[ta_out[DAW-1:PBW]]));
  assert_auth_needed_R9: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && ($past(ta_out) < 16'(DATA_BYTES))) |-> $past(auth_ok));
  assert_outcome_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(copy_done && copy_err));
  assert_range_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(ta_out) <= 16'(DATA_BYTES)));
endmodule

// File: tb/tb_scp_top.sv
module tb_scp_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_first = 1'b0, in_end = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        crc_valid;
  logic [15:0] crc_out, ta_out;
  logic [7:0]  status_out;
  logic        copy_req = 1'b0, auth_ok = 1'b0, eprom_en = 1'b0;
  logic [3:0]  wp_pages = 4'h0;
  logic [1:0]  eprom_page = 2'd0;
  logic        busy, copy_done, copy_err;
  logic        rd_req = 1'b0;
  logic [6:0]  rd_addr = 7'd0;
  logic        rd_valid;
  logic [7:0]  rd_data;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  scp_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first), .in_byte(in_byte),
    .in_end(in_end), .crc_valid(crc_valid), .crc_out(crc_out), .ta_out(ta_out),
    .status_out(status_out), .copy_req(copy_req), .auth_ok(auth_ok), .wp_pages(wp_pages),
    .eprom_en(eprom_en), .eprom_page(eprom_page), .busy(busy), .copy_done(copy_done),
    .copy_err(copy_err), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  typedef struct packed {
    logic [15:0] ta;
    logic [3:0]  n;
    logic [63:0] d;
    logic [7:0]  st;
    logic [15:0] ta_exp;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{16'h0013, 4'd8, 64'h8877665544332211, 8'h5F, 16'h0010},
    '{16'h0045, 4'd3, 64'h00000000000000C3, 8'hDA, 16'h0040},
    '{16'h007F, 4'd8, 64'hFFEEDDCCBBAA9988, 8'h5F, 16'h0078},
    '{16'h0000, 4'd0, 64'h0,                8'hD8, 16'h0000},
    '{16'h1287, 4'd8, 64'h0102030405060708, 8'h5F, 16'h1280},
    '{16'h00A9, 4'd7, 64'h00A5A5A5A5A5A5A5, 8'hDE, 16'h00A8}
  };

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] s;
    s = c;
    for (int k = 0; k < 8; k++) begin
      logic fb;
      fb = s[0] ^ b[k];
      s = {1'b0, s[15:1]};
      if (fb) s = s ^ 16'hA001;
    end
    return s;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic f);
    in_valid = 1'b1; in_byte = b; in_first = f;
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0;
  endtask

  task automatic end_frame();
    in_end = 1'b1;
    @(negedge clk);
    in_end = 1'b0;
  endtask

  task automatic write_spad(input logic [15:0] ta, input logic [63:0] d, input int n);
    logic [15:0] c;
    c = ref_crc(16'h0, 8'h0F);
    send_byte(8'h0F, 1'b1);
    c = ref_crc(c, ta[7:0]);  send_byte(ta[7:0], 1'b0);
    c = ref_crc(c, ta[15:8]); send_byte(ta[15:8], 1'b0);
    for (int i = 0; i < n; i++) begin
      c = ref_crc(c, d[8*i +: 8]);
      send_byte(d[8*i +: 8], 1'b0);
    end
    if (n == 8) begin
      chk(crc_valid === 1'b1, "R6 crc_valid", {63'h0, crc_valid}, 64'h1);
      chk(crc_out === ~c, "R6 crc value", {48'h0, crc_out}, {48'h0, ~c});
      @(negedge clk);
      chk(crc_valid === 1'b0, "R6 crc pulse width", {63'h0, crc_valid}, 64'h0);
    end else begin
      chk(crc_valid === 1'b0, "R4 no crc on partial", {63'h0, crc_valid}, 64'h0);
    end
  endtask

  task automatic do_copy(output int cyc, output logic errs);
    copy_req = 1'b1;
    @(negedge clk);
    copy_req = 1'b0;
    errs = copy_err;
    cyc = 0;
    if (!errs) begin
      while (!copy_done && cyc < 40) begin
        @(negedge clk);
        cyc++;
      end
    end
    @(negedge clk);
  endtask

  task automatic rd_byte(input logic [6:0] a, output logic [7:0] v);
    rd_req = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_req = 1'b0;
    v = rd_valid ? rd_data : 8'hXX;
  endtask

  task automatic check_mem(input logic [6:0] base, input logic [63:0] exp, input string req);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      rd_byte(base + 7'(i), v);
      chk(v === exp[8*i +: 8], req, {56'h0, v}, {56'h0, exp[8*i +: 8]});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int cyc;
    logic e;
    localparam logic [63:0] D1 = 64'h1122334455667788;
    localparam logic [63:0] D2 = 64'hDEADBEEFCAFEF00D;
    localparam logic [63:0] PA = 64'hF0F0AAAA55550F0F;
    localparam logic [63:0] PB = 64'h3C3CFF00FF00C3C3;
    localparam logic [63:0] PC = 64'h0123456789ABCDEF;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(status_out === 8'hD8, "R1 R5 reset status", {56'h0, status_out}, 64'hD8);
    chk(ta_out === 16'h0, "R1 reset ta", {48'h0, ta_out}, 64'h0);
    chk({crc_valid, busy, copy_done, copy_err} === 4'b0, "R1 reset flags",
        {60'h0, crc_valid, busy, copy_done, copy_err}, 64'h0);

    // table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < 6; v++) begin
      write_spad(VEC[v].ta, VEC[v].d, int'(VEC[v].n));
      end_frame();
      chk(status_out === VEC[v].st, "R3 R4 R5 status", {56'h0, status_out}, {56'h0, VEC[v].st});
      chk(ta_out === VEC[v].ta_exp, "R2 aligned address", {48'h0, ta_out}, {48'h0, VEC[v].ta_exp});
    end

    // R13: a ninth byte is ignored; then R10 normal commit
    auth_ok = 1'b1;
    write_spad(16'h0020, D1, 8);
    send_byte(8'hEE, 1'b0);
    chk(crc_valid === 1'b0, "R13 no crc after extra byte", {63'h0, crc_valid}, 64'h0);
    chk(status_out === 8'h5F, "R13 status unchanged", {56'h0, status_out}, 64'h5F);
    end_frame();
    do_copy(cyc, e);
    chk(e === 1'b0, "R10 copy accepted", {63'h0, e}, 64'h0);
    chk(cyc == 8, "R10 done latency", 64'(cyc), 64'd8);
    check_mem(7'h20, D1, "R10 R13 stored bytes");

    // R7: partial load refused
    write_spad(16'h0020, D2, 3);
    end_frame();
    do_copy(cyc, e);
    chk(e === 1'b1, "R7 partial refused", {63'h0, e}, 64'h1);
    check_mem(7'h20, D1, "R7 memory unchanged");

    // R8: write protection
    write_spad(16'h0020, D2, 8);
    end_frame();
    wp_pages = 4'b0010;
    do_copy(cyc, e);
    chk(e === 1'b1, "R8 protected refused", {63'h0, e}, 64'h1);
    check_mem(7'h20, D1, "R8 memory unchanged");
    wp_pages = 4'b0000;

    // R9: authorization
    auth_ok = 1'b0;
    do_copy(cyc, e);
    chk(e === 1'b1, "R9 no auth refused", {63'h0, e}, 64'h1);
    check_mem(7'h20, D1, "R9 memory unchanged");
    write_spad(16'h0080, D2, 8);
    end_frame();
    do_copy(cyc, e);
    chk(e === 1'b0 && cyc == 8, "R9 secret without auth", 64'(cyc), 64'd8);

    // R12: out-of-range targets
    auth_ok = 1'b1;
    write_spad(16'h0088, D2, 8);
    end_frame();
    do_copy(cyc, e);
    chk(e === 1'b1, "R12 0x0088 refused", {63'h0, e}, 64'h1);
    write_spad(16'h0100, D2, 8);
    end_frame();
    do_copy(cyc, e);
    chk(e === 1'b1, "R12 0x0100 refused", {63'h0, e}, 64'h1);

    // R11: 1-to-0-only page
    write_spad(16'h0040, PA, 8);
    end_frame();
    do_copy(cyc, e);
    chk(e === 1'b0, "R11 preload", {63'h0, e}, 64'h0);
    eprom_en = 1'b1; eprom_page = 2'd2;
    write_spad(16'h0040, PB, 8);
    end_frame();
    do_copy(cyc, e);
    chk(e === 1'b0 && cyc == 17, "R11 latency", 64'(cyc), 64'd17);
    check_mem(7'h40, PA & PB, "R11 AND stored");
    write_spad(16'h0000, PC, 8);
    end_frame();
    do_copy(cyc, e);
    chk(e === 1'b0 && cyc == 8, "R11 other page normal", 64'(cyc), 64'd8);
    check_mem(7'h00, PC, "R11 other page plain write");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule